// File: doc/BRIEF.md
# Sampled-Input Timer/Counter Unit

This block holds three independent 16-bit up-counters of the classic 8-bit microcontroller kind. Software reaches them through a byte-wide special-function-register port. Each channel has a mode-select input that picks one of two count sources:

- **Timer mode:** the channel counts a fixed tick. The tick comes from a free-running divide-by-12 prescaler on the system clock, and nothing else gates it.
- **Event-counter mode:** the channel counts falling transitions of its own external pin. These transitions are found only by comparing successive samples taken on the tick, never by watching the fast clock.

An event needs one sample that reads high followed by one that reads low. The count moves at the tick after that, so the fastest event rate is one per 24 system clocks. A pin level shorter than one tick period may go unseen.

Each channel counts only while its run input is high. When it rolls over from FFFFh to 0000h it raises an overflow flag. Software clears that flag through a flag register.

Top module: `tick_counter_unit`

## Requirements
- R1: After reset every count byte, every overflow flag and the sampling history read 0, and the prescaler restarts so that the first tick-driven update lands on the 12th rising clock edge after reset is released.
- R2: Reads are combinational from `sfr_addr`. Count bytes are at the following addresses: channel 0 high 8Ch and low 8Ah, channel 1 high 8Dh and low 8Bh, channel 2 high CDh and low CCh. The flag register is at 8Fh, with bit n holding channel n's overflow flag and the upper bits reading 0. Any other address reads 00h.
- R3: With `cnt_mode[n]`=0 (timer) and `run_en[n]`=1, channel n increments by exactly 1 once every 12 clocks, so any 120-clock window adds exactly 10.
- R4: With `cnt_mode[n]`=1 (event), channel n increments once for each pair of tick samples that reads 1 and then 0, one tick period after the low sample. This gives the following:
  - a pin with 12-clock high and 12-clock low levels adds 10 in any 240-clock window;
  - a pin with 24-clock levels adds 10 in 480 clocks;
  - a constant pin adds nothing;
  - a pin toggling every clock adds nothing.
- R5: A roll-over from FFFFh to 0000h sets the channel's flag. Writing the flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A roll-over in the same cycle as a clearing write leaves the flag set.
- R6: A write to a count byte replaces that byte on the next edge, keeps the other byte, and takes priority over an increment due in the same cycle. The written value is readable in the following cycle.
- R7: While `run_en[n]`=0 the count of channel n holds its value, while pin sampling continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_we | input | 1 | Write strobe, one write per asserted cycle |
| sfr_rdata | output | 8 | Read data for `sfr_addr` |
| cnt_pin | input | 3 | External event inputs, one per channel |
| run_en | input | 3 | Per-channel count enable |
| cnt_mode | input | 3 | Per-channel source select: 0 timer, 1 event |
| ovf_flag | output | 3 | Per-channel overflow flags |

## Verification
The embedded properties check the following on every cycle:

- the tick never asserts on two consecutive clocks;
- a timer step is exactly +1;
- a byte write lands its data and spares the other byte;
- a held channel stays still;
- a roll-over leaves zero with the flag up;
- an event is never counted twice from one falling sample pair.

The count rates over windows, the filtering of a pin that toggles every clock, the address map, the flag-clear mask, and the alignment of writes and flag clears against a tick edge can only be shown by the bench's scenarios. Those scenarios track tick phase from the moment reset is released.

// File: rtl/tcu_pkg.sv
`timescale 1ns/1ps
package tcu_pkg;
   typedef enum logic {
      SRC_TICK  = 1'b0,
      SRC_EVENT = 1'b1
   } count_src_e;

   localparam logic [7:0] DEF_FLAG_ADDR = 8'h8F;
   localparam logic [23:0] DEF_HI_ADDRS = {8'hCD, 8'h8D, 8'h8C};
   localparam logic [23:0] DEF_LO_ADDRS = {8'hCC, 8'h8B, 8'h8A};
endpackage

// File: rtl/tcu_prescaler.sv
`timescale 1ns/1ps
module tcu_prescaler #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tcu_prescaler: DIV must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);

   // R3: the tick is a single-cycle strobe
   a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/tcu_pin_sampler.sv
`timescale 1ns/1ps
module tcu_pin_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic fall,
   output logic older_smp
);
   logic pin_s;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q <= '0;
            else begin
               sync_q[0] <= pin;
               for (int i = 1; i < SYNC_STAGES; i++)
                  sync_q[i] <= sync_q[i-1];
            end
         end
         assign pin_s = sync_q[SYNC_STAGES-1];
      end else begin : g_direct
         assign pin_s = pin;
      end
   endgenerate

   logic newer_q, older_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         newer_q <= 1'b0;
         older_q <= 1'b0;
      end else if (tick) begin
         older_q <= newer_q;
         newer_q <= pin_s;
      end
   end

   assign fall      = older_q & ~newer_q;
   assign older_smp = older_q;

   // R7: samples only move on a tick
   a_r7_samples_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(older_q));
endmodule

// File: rtl/tcu_channel.sv
`timescale 1ns/1ps
module tcu_channel
   import tcu_pkg::*;
#(
   parameter int unsigned W  = 16,
   parameter int unsigned DW = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          pin,
   input  logic          run,
   input  count_src_e    src,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   input  logic          flag_wr,
   input  logic          flag_keep,
   output logic [W-1:0]  count,
   output logic          ovf
);
   generate
      if (W != 2 * DW) begin : g_bad_width
         $error("tcu_channel: counter must be two data bytes wide");
      end
   endgenerate

   logic fall, older_smp;

   tcu_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pin       (pin),
      .fall      (fall),
      .older_smp (older_smp)
   );

   logic step, any_wr, wrap;
   logic [W-1:0] count_q;

   assign step   = run & tick & ((src == SRC_EVENT) ? fall : 1'b1);
   assign any_wr = wr_lo | wr_hi;
   assign wrap   = step & ~any_wr & (&count_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (any_wr) begin
         if (wr_lo) count_q[DW-1:0] <= wdata;
         if (wr_hi) count_q[W-1:DW] <= wdata;
      end else if (step)
         count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (wrap)
         ovf <= 1'b1;
      else if (flag_wr && !flag_keep)
         ovf <= 1'b0;
   end

   assign count = count_q;

   // R6: written low byte lands, high byte is spared
   a_r6_write_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (count_q[DW-1:0] == $past(wdata)) &&
                            (count_q[W-1:DW] == $past(count_q[W-1:DW])));
   // R6: written high byte lands, low byte is spared
   a_r6_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (count_q[W-1:DW] == $past(wdata)) &&
                            (count_q[DW-1:0] == $past(count_q[DW-1:0])));
   // R7: a stopped channel holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !any_wr) |=> $stable(count_q));
   // R3: a timer step is exactly one
   a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && src == SRC_TICK && tick && !any_wr) |=> count_q == $past(count_q) + 1'b1);
   // R5: roll-over leaves zero with the flag set
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !any_wr && (&count_q) && (src == SRC_TICK || fall)) |=> (count_q == '0) && ovf);
   // R4: one falling pair yields one event only
   a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && fall) |=> !older_smp);
endmodule

// File: rtl/tick_counter_unit.sv
`timescale 1ns/1ps
module tick_counter_unit
   import tcu_pkg::*;
#(
   parameter int unsigned NCH = 3,
   parameter int unsigned AW  = 8,
   parameter int unsigned DW  = 8,
   parameter int unsigned W   = 16,
   parameter int unsigned PRESCALE    = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [NCH*AW-1:0] HI_ADDRS  = DEF_HI_ADDRS,
   parameter logic [NCH*AW-1:0] LO_ADDRS  = DEF_LO_ADDRS,
   parameter logic [AW-1:0]     FLAG_ADDR = DEF_FLAG_ADDR
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  sfr_addr,
   input  logic [DW-1:0]  sfr_wdata,
   input  logic           sfr_we,
   output logic [DW-1:0]  sfr_rdata,
   input  logic [NCH-1:0] cnt_pin,
   input  logic [NCH-1:0] run_en,
   input  logic [NCH-1:0] cnt_mode,
   output logic [NCH-1:0] ovf_flag
);
   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("tick_counter_unit: channel count must fit the flag register");
      end
   endgenerate

   logic tick;
   logic [W-1:0] counts [NCH];
   logic flag_wr;

   assign flag_wr = sfr_we && (sfr_addr == FLAG_ADDR);

   tcu_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic wr_lo, wr_hi;
      assign wr_lo = sfr_we && (sfr_addr == LO_ADDRS[g*AW +: AW]);
      assign wr_hi = sfr_we && (sfr_addr == HI_ADDRS[g*AW +: AW]);

      tcu_channel #(.W(W), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .pin       (cnt_pin[g]),
         .run       (run_en[g]),
         .src       (count_src_e'(cnt_mode[g])),
         .wr_lo     (wr_lo),
         .wr_hi     (wr_hi),
         .wdata     (sfr_wdata),
         .flag_wr   (flag_wr),
         .flag_keep (sfr_wdata[g]),
         .count     (counts[g]),
         .ovf       (ovf_flag[g])
      );
   end

   always_comb begin
      sfr_rdata = '0;
      if (sfr_addr == FLAG_ADDR)
         sfr_rdata = DW'(ovf_flag);
      for (int i = 0; i < NCH; i++) begin
         if (sfr_addr == LO_ADDRS[i*AW +: AW]) sfr_rdata = counts[i][DW-1:0];
         if (sfr_addr == HI_ADDRS[i*AW +: AW]) sfr_rdata = counts[i][W-1:DW];
      end
   end

   // R5: a flag only rises together with a tick
   a_r5_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !$rose(ovf_flag));
endmodule

// File: tb/tb_tick_counter_unit.sv
`timescale 1ns/1ps
module tb_tick_counter_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
   logic sfr_we = 1'b0;
   logic [2:0] cnt_pin = '0, run_en = '0, cnt_mode = '0, ovf_flag;

   int errors = 0, checks = 0, ecount = 0;
   int half [3] = '{0, 0, 0};
   int ph [3] = '{0, 0, 0};
   logic done = 1'b0;
   localparam logic [7:0] HI [3] = '{8'h8C, 8'h8D, 8'hCD};
   localparam logic [7:0] LO [3] = '{8'h8A, 8'h8B, 8'hCC};
   localparam logic [7:0] FLG = 8'h8F;

   tick_counter_unit dut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .cnt_pin(cnt_pin),
      .run_en(run_en), .cnt_mode(cnt_mode), .ovf_flag(ovf_flag)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) ecount <= 0;
      else ecount <= ecount + 1;
   end

   always @(negedge clk) begin
      for (int c = 0; c < 3; c++) begin
         if (half[c] > 0) begin
            ph[c] = ph[c] + 1;
            if (ph[c] >= half[c]) begin
               ph[c] = 0;
               cnt_pin[c] = ~cnt_pin[c];
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      sfr_addr = a;
      #1;
      v = int'(sfr_rdata);
   endtask

   task automatic rd16(input int c, output int v);
      int h, l;
      rd(HI[c], h);
      rd(LO[c], l);
      v = (h << 8) | l;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sfr_we = 1'b0;
   endtask

   task automatic wait_phase(input int p);
      @(negedge clk);
      while ((ecount % 12) != p) @(negedge clk);
   endtask

   task automatic window(input int c, input int n, output int d);
      int a, b;
      rd16(c, a);
      repeat (n) @(negedge clk);
      rd16(c, b);
      d = (b - a) & 16'hFFFF;
   endtask

   initial begin
      int v, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int c = 0; c < 3; c++) begin
         rd16(c, v);
         check("R1 count", v, 0);
      end
      rd(FLG, v);
      check("R1 flags", v, 0);

      // R2 address map
      wr(HI[0], 8'h12); wr(LO[0], 8'h34); wr(LO[1], 8'hAB);
      rd16(0, v); check("R2 ch0", v, 16'h1234);
      rd16(1, v); check("R2 ch1", v, 16'h00AB);
      rd(8'h8E, v); check("R2 unmapped", v, 0);

      // R3 R4 R7 sweep over channels
      for (int c = 0; c < 3; c++) begin
         cnt_mode[c] = 1'b0; run_en[c] = 1'b1;
         window(c, 120, d); check("R3 timer rate", d, 10);
         run_en[c] = 1'b0;
         window(c, 120, d); check("R7 hold", d, 0);
         cnt_mode[c] = 1'b1; run_en[c] = 1'b1;
         half[c] = 12; repeat (48) @(negedge clk);
         window(c, 240, d); check("R4 12-clock levels", d, 10);
         half[c] = 24; repeat (96) @(negedge clk);
         window(c, 480, d); check("R4 24-clock levels", d, 10);
         half[c] = 1; repeat (48) @(negedge clk);
         window(c, 240, d); check("R4 fast toggle filtered", d, 0);
         half[c] = 0; cnt_pin[c] = 1'b1; repeat (48) @(negedge clk);
         window(c, 240, d); check("R4 constant pin", d, 0);
         run_en[c] = 1'b0; cnt_mode[c] = 1'b0; cnt_pin[c] = 1'b0;
      end

      // R5 overflow on channel 1
      wr(HI[1], 8'hFF); wr(LO[1], 8'hFE);
      run_en[1] = 1'b1;
      repeat (36) @(negedge clk);
      run_en[1] = 1'b0;
      rd16(1, v); check("R5 wrapped count", v, 1);
      rd(FLG, v); check("R5 flag set", v, 3'b010);
      check("R5 flag pin", int'(ovf_flag), 3'b010);
      wr(FLG, 8'hFF);
      rd(FLG, v); check("R5 write one keeps", v, 3'b010);
      wr(FLG, 8'hFD);
      rd(FLG, v); check("R5 write zero clears", v, 0);

      // R6 write wins over a tick increment
      wr(HI[0], 8'h05); wr(LO[0], 8'h00);
      run_en[0] = 1'b1;
      wait_phase(11);
      wr(LO[0], 8'h40);
      rd16(0, v); check("R6 write beats step", v, 16'h0540);
      repeat (12) @(negedge clk);
      rd16(0, v); check("R6 step after write", v, 16'h0541);
      run_en[0] = 1'b0;

      // R5 set beats clear, R1 tick alignment
      wr(HI[2], 8'hFF); wr(LO[2], 8'hFF);
      wait_phase(11);
      run_en[2] = 1'b1;
      wr(FLG, 8'h00);
      run_en[2] = 1'b0;
      rd(FLG, v); check("R5 set beats clear", v, 3'b100);
      rd16(2, v); check("R1 tick on 12th edge", v, 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule